// File: doc/BRIEF.md
# Command Queue with Open-Row Tracking

This block sits between a user request port and a DRAM command sequencer. The user side offers read and write requests. Each request carries a two-bit command code, a linear start address and a burst-size field. Accepted requests wait in a small first-in first-out queue until the sequencer pops them. The block does not issue DRAM commands, check timing or move data. It only holds the requests in order and tells the sequencer what the request at the head of the queue needs.

The block keeps a table with one entry per memory bank, four banks in all. Each entry holds an open flag and the page that is open in that bank, where a page is a chip select together with a row. Any number of banks can be open at once. The request at the head is classed against this table in one of three ways. It is a hit when its bank is open on the same page. It is idle when its bank is closed, so only an activate is needed. It is a miss when its bank is open on another page, so a precharge and then an activate are needed. The sequencer writes the table as it issues commands: it records an activated page, closes a single bank after a precharge, or closes every bank at once. Rows are never closed on their own, so a later request to the same page is still a hit.

Flow control on the request side follows these rules. A request is taken on any clock edge where `req_valid` is high and `req_busy` is low. `req_busy` is high exactly while the queue is full. While it is high, the user must keep the request on the port. The head side is a plain valid/pop pair: `head_pop` is honoured only while `head_valid` is high.

Top module: `cmdq_bank_tracker`

## Requirements
- R1: After reset the queue is empty (`head_valid`=0, `req_busy`=0) and all four banks are closed.
- R2: `req_busy` is 1 exactly when the queue holds DEPTH entries (default 4). It stays 1 until a pop happens, and it is 0 on the cycle after a pop from a full queue.
- R3: A request is accepted only on a clock edge with `req_valid`=1 and `req_busy`=0. A request offered while busy is not queued.
- R4: Command code 2'b01 is a read and 2'b10 is a write (`head_write`=1). Codes 2'b00 and 2'b11 are accepted and then discarded, so they never reach the head.
- R5: Entries leave the queue in the order they were accepted. A pop removes the head, and the next entry is shown on the following cycle.
- R6: The address is split with the lowest COL_W bits (4) as column, the next 2 bits as bank, the next ROW_W bits (6) as row, and the top CS_W bit (1) as chip select. The head outputs show these fields.
- R7: `head_size` echoes the size field (0..3 means 1..4 user words), and `head_beats` equals 2*(size+1) DDR transfers.
- R8: `head_class` is 2'b00 (hit) when the head's bank is open on the same chip select and row. It is 2'b01 (idle) when that bank is closed, and 2'b10 (miss) when that bank is open on a different chip select or row.
- R9: `upd_en` with `upd_open`=1 records `upd_cs`/`upd_row` as the open page of `upd_bank`. With `upd_open`=0 it closes that bank. The other banks are not changed.
- R10: `pre_all` closes every bank within one cycle. If it comes in the same cycle as `upd_en`, it wins.
- R11: A page stays open across any number of accesses and pops. All four banks can be open at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_code | input | 2 | Command code: 01 read, 10 write, others dropped |
| req_addr | input | 13 | Linear start address |
| req_size | input | 2 | Burst size minus one, in user words |
| req_busy | output | 1 | Queue full, request not taken |
| head_valid | output | 1 | Head entry present |
| head_write | output | 1 | Head is a write |
| head_size | output | 2 | Head burst size field |
| head_beats | output | 4 | DDR transfers for the head burst |
| head_col | output | 4 | Head column |
| head_bank | output | 2 | Head bank |
| head_row | output | 6 | Head row |
| head_cs | output | 1 | Head chip select |
| head_class | output | 2 | 00 hit, 01 idle, 10 miss |
| head_pop | input | 1 | Remove head entry |
| upd_en | input | 1 | Write one bank's table entry |
| upd_open | input | 1 | 1 records an open page, 0 closes the bank |
| upd_bank | input | 2 | Bank to update |
| upd_row | input | 6 | Row being opened |
| upd_cs | input | 1 | Chip select of the row being opened |
| pre_all | input | 1 | Close all banks |

## Verification
The hardest case to reach is a miss caused only by the chip select. Both chip selects share one bank table, so the bench opens a bank on one chip select and then queues a request with the same bank and row on the other chip select. The second hard case is `pre_all` and a bank update arriving in the same cycle. The bench drives both on one edge and then queues a request to that bank to show the bank is closed. A third case is the full queue. The bench fills it, holds a request on the port across the busy cycles, and then drains the queue. This shows that the held request was never taken.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [1:0] {
    CLS_HIT  = 2'b00,
    CLS_IDLE = 2'b01,
    CLS_MISS = 2'b10
  } row_class_e;

  localparam logic [1:0] CODE_READ  = 2'b01;
  localparam logic [1:0] CODE_WRITE = 2'b10;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             full,
  output logic             not_empty,
  output logic [WIDTH-1:0] head_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic do_push, do_pop;

  assign full      = (count == FULLC);
  assign not_empty = (count != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;
  assign head_data = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        store[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_EMPTY_FILL: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && push) |=> not_empty);  // R5
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);  // R2
  AST_POP_FREES: assert property (@(posedge clk) disable iff (rst)
    (full && pop) |=> !full);  // R2
endmodule

// File: rtl/cmdq_addr_split.sv
module cmdq_addr_split #(
  parameter int COL_W  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 6,
  parameter int CS_W   = 1
) (
  input  logic [COL_W+BANK_W+ROW_W+CS_W-1:0] addr,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [CS_W-1:0]   cs
);
  localparam int BANK_LO = COL_W;
  localparam int ROW_LO  = COL_W + BANK_W;
  localparam int CS_LO   = COL_W + BANK_W + ROW_W;

  assign col  = addr[COL_W-1:0];
  assign bank = addr[BANK_LO +: BANK_W];
  assign row  = addr[ROW_LO +: ROW_W];
  assign cs   = addr[CS_LO +: CS_W];
endmodule

// File: rtl/cmdq_row_table.sv
module cmdq_row_table
  import cmdq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic              upd_open,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic              pre_all,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [PAGE_W-1:0] look_page,
  output row_class_e        look_class
);
  localparam int NB = 1 << BANK_W;

  logic [NB-1:0] open_q;
  logic [PAGE_W-1:0] page_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst || pre_all) begin
        open_q[b] <= 1'b0;
      end else if (upd_en && upd_bank == BANK_W'(b)) begin
        open_q[b] <= upd_open;
        if (upd_open) page_q[b] <= upd_page;
      end
    end
  end

  always_comb begin
    if (!open_q[look_bank])                 look_class = CLS_IDLE;
    else if (page_q[look_bank] == look_page) look_class = CLS_HIT;
    else                                     look_class = CLS_MISS;
  end

  AST_PREALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    pre_all |=> (open_q == '0));  // R10
  AST_UPD_RECORDS: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_open && !pre_all) |=> open_q[$past(upd_bank)]);  // R9
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !pre_all) |=> ($countones(open_q ^ $past(open_q)) <= 1));  // R9
  AST_NO_SELF_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (!upd_en && !pre_all) |=> $stable(open_q));  // R11
endmodule

// File: rtl/cmdq_bank_tracker.sv
module cmdq_bank_tracker
  import cmdq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int COL_W  = 4,
  parameter int ROW_W  = 6,
  parameter int CS_W   = 1,
  parameter int ADDR_W = COL_W + 2 + ROW_W + CS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_code,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              req_busy,
  output logic              head_valid,
  output logic              head_write,
  output logic [1:0]        head_size,
  output logic [3:0]        head_beats,
  output logic [COL_W-1:0]  head_col,
  output logic [1:0]        head_bank,
  output logic [ROW_W-1:0]  head_row,
  output logic [CS_W-1:0]   head_cs,
  output logic [1:0]        head_class,
  input  logic              head_pop,
  input  logic              upd_en,
  input  logic              upd_open,
  input  logic [1:0]        upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  input  logic [CS_W-1:0]   upd_cs,
  input  logic              pre_all
);
  localparam int BANK_W  = 2;
  localparam int PAGE_W  = CS_W + ROW_W;
  localparam int ENTRY_W = 1 + 2 + ADDR_W;

  logic              code_ok, push;
  logic [ENTRY_W-1:0] head_entry;
  logic [ADDR_W-1:0] head_addr;
  row_class_e        cls;

  assign code_ok = (req_code == CODE_READ) || (req_code == CODE_WRITE);
  assign push    = req_valid && code_ok;

  cmdq_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data ({req_code == CODE_WRITE, req_size, req_addr}),
    .pop       (head_pop),
    .full      (req_busy),
    .not_empty (head_valid),
    .head_data (head_entry)
  );

  assign head_write = head_entry[ENTRY_W-1];
  assign head_size  = head_entry[ADDR_W +: 2];
  assign head_addr  = head_entry[ADDR_W-1:0];
  assign head_beats = {1'b0, head_size, 1'b0} + 4'd2;

  cmdq_addr_split #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .CS_W(CS_W)) u_split (
    .addr (head_addr),
    .col  (head_col),
    .bank (head_bank),
    .row  (head_row),
    .cs   (head_cs)
  );

  cmdq_row_table #(.BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (upd_en),
    .upd_open   (upd_open),
    .upd_bank   (upd_bank),
    .upd_page   ({upd_cs, upd_row}),
    .pre_all    (pre_all),
    .look_bank  (head_bank),
    .look_page  ({head_cs, head_row}),
    .look_class (cls)
  );

  assign head_class = cls;

  AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !code_ok && !head_valid) |=> !head_valid);  // R4
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (req_busy && !head_pop) |=> req_busy);  // R3
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    head_valid |-> (head_class != 2'b11));  // R8
endmodule

// File: tb/cmdq_bank_tracker_bench.sv
module cmdq_bank_tracker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 0;
  logic [1:0]  req_code = 0;
  logic [12:0] req_addr = 0;
  logic [1:0]  req_size = 0;
  logic        req_busy, head_valid, head_write;
  logic [1:0]  head_size, head_bank, head_class;
  logic [3:0]  head_beats, head_col;
  logic [5:0]  head_row;
  logic [0:0]  head_cs;
  logic        head_pop = 0, upd_en = 0, upd_open = 0, pre_all = 0;
  logic [1:0]  upd_bank = 0;
  logic [5:0]  upd_row = 0;
  logic [0:0]  upd_cs = 0;

  cmdq_bank_tracker u_cmdq_bank_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .req_addr(req_addr), .req_size(req_size), .req_busy(req_busy),
    .head_valid(head_valid), .head_write(head_write), .head_size(head_size),
    .head_beats(head_beats), .head_col(head_col), .head_bank(head_bank),
    .head_row(head_row), .head_cs(head_cs), .head_class(head_class),
    .head_pop(head_pop), .upd_en(upd_en), .upd_open(upd_open),
    .upd_bank(upd_bank), .upd_row(upd_row), .upd_cs(upd_cs), .pre_all(pre_all)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      report();
    end
  end

  task automatic push(input logic [1:0] code, input logic [12:0] a, input logic [1:0] sz);
    @(negedge clk);
    req_valid = 1; req_code = code; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pop();
    @(negedge clk); head_pop = 1;
    @(negedge clk); head_pop = 0;
  endtask

  task automatic upd(input logic op, input logic [1:0] b, input logic [5:0] r, input logic c);
    @(negedge clk);
    upd_en = 1; upd_open = op; upd_bank = b; upd_row = r; upd_cs = c;
    @(negedge clk);
    upd_en = 0;
  endtask

  function automatic logic [12:0] mk(input logic c, input logic [5:0] r,
                                     input logic [1:0] b, input logic [3:0] col);
    return {c, r, b, col};
  endfunction

  // vector: upd_en, upd_open, upd_bank, upd_cs, upd_row | addr | size | code | class | pad
  localparam logic [31:0] VEC [8] = '{
    {1'b0, 1'b0, 2'd0, 1'b0, 6'd0,  1'b0, 6'd5, 2'd1, 4'd3,  2'd0, 2'b01, 2'b01, 2'd0},
    {1'b1, 1'b1, 2'd1, 1'b0, 6'd5,  1'b0, 6'd5, 2'd1, 4'd7,  2'd3, 2'b10, 2'b00, 2'd0},
    {1'b0, 1'b0, 2'd0, 1'b0, 6'd0,  1'b0, 6'd6, 2'd1, 4'd0,  2'd1, 2'b01, 2'b10, 2'd0},
    {1'b1, 1'b1, 2'd2, 1'b1, 6'd9,  1'b0, 6'd9, 2'd2, 4'd1,  2'd2, 2'b10, 2'b10, 2'd0},
    {1'b0, 1'b0, 2'd0, 1'b0, 6'd0,  1'b1, 6'd9, 2'd2, 4'd15, 2'd0, 2'b01, 2'b00, 2'd0},
    {1'b0, 1'b0, 2'd0, 1'b0, 6'd0,  1'b0, 6'd5, 2'd1, 4'd9,  2'd1, 2'b01, 2'b00, 2'd0},
    {1'b1, 1'b0, 2'd1, 1'b0, 6'd0,  1'b0, 6'd5, 2'd1, 4'd2,  2'd0, 2'b10, 2'b01, 2'd0},
    {1'b0, 1'b0, 2'd0, 1'b0, 6'd0,  1'b0, 6'd0, 2'd0, 4'd4,  2'd3, 2'b01, 2'b01, 2'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(head_valid == 0, "R1 head_valid", head_valid, 0);
    chk(req_busy == 0, "R1 busy", req_busy, 0);
    push(2'b01, mk(1'b0, 6'd1, 2'd3, 4'd0), 2'd0);
    chk(head_class == 2'b01, "R1 bank closed", head_class, 1);
    pop();

    // R8 R6 R7 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = VEC[i];
      if (v[31]) upd(v[30], v[29:28], v[26:21], v[27]);
      push(v[5:4], v[20:8], v[7:6]);
      chk(head_valid == 1, "R5 vec head", head_valid, 1);
      chk(head_class == v[3:2], "R8 vec class", head_class, v[3:2]);
      chk(head_write == (v[5:4] == 2'b10), "R4 vec write", head_write, v[5:4] == 2'b10);
      chk({head_cs, head_row, head_bank, head_col} == v[20:8], "R6 vec fields",
          {head_cs, head_row, head_bank, head_col}, v[20:8]);
      chk(head_size == v[7:6], "R7 vec size", head_size, v[7:6]);
      chk(head_beats == 4'(2 * (v[7:6] + 1)), "R7 vec beats", head_beats, 2 * (v[7:6] + 1));
      pop();
    end
    chk(head_valid == 0, "R5 drained", head_valid, 0);

    // R4 reserved codes
    push(2'b00, 13'd0, 2'd0);
    chk(head_valid == 0, "R4 code 00 dropped", head_valid, 0);
    push(2'b11, 13'd0, 2'd0);
    chk(head_valid == 0, "R4 code 11 dropped", head_valid, 0);

    // R2 R3 R5 fill, hold while busy, drain
    for (int k = 0; k < 4; k++) push(2'b01, mk(1'b0, 6'd2, 2'd0, 4'(k)), 2'd0);
    chk(req_busy == 1, "R2 busy when full", req_busy, 1);
    @(negedge clk);
    req_valid = 1; req_code = 2'b10; req_addr = mk(1'b0, 6'd2, 2'd0, 4'd9);
    repeat (3) @(negedge clk);
    req_valid = 0;
    chk(req_busy == 1, "R2 busy held", req_busy, 1);
    chk(head_col == 0, "R5 order first", head_col, 0);
    pop();
    chk(req_busy == 0, "R2 busy drops after pop", req_busy, 0);
    for (int k = 1; k < 4; k++) begin
      chk(head_col == 4'(k), "R5 order", head_col, k);
      chk(head_write == 0, "R3 held request not taken", head_write, 0);
      pop();
    end
    chk(head_valid == 0, "R3 nothing extra queued", head_valid, 0);

    // R11 all four banks open, R10 pre_all
    for (int b = 0; b < 4; b++) upd(1'b1, 2'(b), 6'(b + 10), 1'b0);
    for (int b = 0; b < 4; b++) begin
      push(2'b01, mk(1'b0, 6'(b + 10), 2'(b), 4'd0), 2'd0);
      chk(head_class == 2'b00, "R11 all open hit", head_class, 0);
      pop();
      push(2'b01, mk(1'b0, 6'(b + 10), 2'(b), 4'd1), 2'd0);
      chk(head_class == 2'b00, "R11 still open after pop", head_class, 0);
      pop();
    end
    @(negedge clk);
    pre_all = 1; upd_en = 1; upd_open = 1; upd_bank = 2'd3; upd_row = 6'd13; upd_cs = 1'b0;
    @(negedge clk);
    pre_all = 0; upd_en = 0;
    for (int b = 0; b < 4; b++) begin
      push(2'b01, mk(1'b0, 6'(b + 10), 2'(b), 4'd0), 2'd0);
      chk(head_class == 2'b01, "R10 closed after pre_all", head_class, 1);
      pop();
    end

    // R9 closing one bank leaves the others
    upd(1'b1, 2'd0, 6'd20, 1'b0);
    upd(1'b1, 2'd1, 6'd21, 1'b0);
    upd(1'b0, 2'd0, 6'd0, 1'b0);
    push(2'b01, mk(1'b0, 6'd21, 2'd1, 4'd0), 2'd0);
    chk(head_class == 2'b00, "R9 other bank kept", head_class, 0);
    pop();
    push(2'b01, mk(1'b0, 6'd20, 2'd0, 4'd0), 2'd0);
    chk(head_class == 2'b01, "R9 bank closed", head_class, 1);
    pop();

    report();
  end
endmodule